// File: doc/BRIEF.md
# Descriptor Receive DMA Sequencer

This block drains received packets from a packet FIFO into host memory. Software posts buffer descriptors, each holding a host address, a byte length and a no-delay flag. For each descriptor, the sequencer issues one DMA write request whose length is the smaller of the descriptor length and the bytes still left in the current packet. When the request is acknowledged, it returns a done word. A packet larger than its buffer is continued by the next descriptor. Packet offset and remaining bytes are kept in a single continuation slot, and that slot is always served before a fresh packet is taken from the FIFO.

Descriptors enter over a valid/ready port. The block holds one descriptor in service and one pending. While a descriptor is pending, `desc_ready` stays low and the source must hold its data stable. The DMA request port is also valid/ready: `dma_addr`, `dma_len` and `dma_pkt_off` stay stable while `dma_req_valid` is high. The request ends when `dma_ack` pulses.

Two optional behaviours change the copy. In short-copy mode, a long copy is cut to a small fixed size while the FIFO is nearly empty. A host address of 1 means no DMA is issued at all. The sequencer yields the DMA port to the transmit side and to any other DMA in flight. After every copy it pulses interrupt events.

Top module: `rxdma_seq`

## Requirements
- R1: A descriptor is taken when `desc_valid` and `desc_ready` are both high. `desc_ready` is low while one descriptor is already pending behind the one in service. Queued descriptors are all served in arrival order.
- R2: If a packet was left partly copied, the next descriptor continues that packet (same class, offset equal to the bytes already copied) instead of taking a fresh packet from the FIFO.
- R3: The copy length is min(descriptor length, bytes remaining in the packet).
- R4: When `short_en` is 1, the descriptor no-delay flag is 0 and `fifo_level` < LOW_MARK, a copy length greater than `short_thresh` becomes `short_size`. If any of these conditions fails, or the length is not above the threshold, R3 applies unchanged.
- R5: A descriptor address of exactly 1 issues no DMA request and still produces a done word as if the copy had been made.
- R6: When a copy finishes a packet, the done word has complete=1, more=0, len=bytes copied and the packet class, and `pkt_pop` pulses for one cycle.
- R7: When a copy does not finish a packet, the done word has complete=1, more=1 and len=bytes still remaining. The packet stays in the FIFO, and the next copy of it starts at an offset advanced by the bytes copied.
- R8: Each done word comes with `irq_dma`. `irq_empty` comes with it too when the copy removed the last packet (`fifo_level` was 1 at removal).
- R9: `dma_req_valid` stays low while `ext_dma_busy` or `tx_wait` is high.
- R10: `cfg_err` is 1 exactly when `short_size` >= `short_thresh`.
- R11: After reset there is no request, no done word and no interrupt, and `desc_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Descriptor slot free |
| desc_addr | input | AW | Host buffer address (1 = skip DMA) |
| desc_len | input | LW | Host buffer length in bytes |
| desc_nodelay | input | 1 | Disable short-copy for this descriptor |
| pkt_valid | input | 1 | FIFO head packet present |
| pkt_len | input | LW | Head packet length |
| pkt_class | input | CW | Head packet protocol classification bits |
| fifo_level | input | FLW | Packets in the FIFO |
| pkt_pop | output | 1 | Remove head packet |
| short_en | input | 1 | Short-copy mode enable |
| short_size | input | LW | Cut-down copy size |
| short_thresh | input | LW | Copy length above which cutting applies |
| cfg_err | output | 1 | Short-copy configuration inconsistent |
| ext_dma_busy | input | 1 | Another DMA is outstanding |
| tx_wait | input | 1 | Transmit side waiting for the DMA port |
| dma_req_valid | output | 1 | DMA write request |
| dma_req_ready | input | 1 | DMA request accepted |
| dma_addr | output | AW | Host address |
| dma_len | output | LW | Bytes to write |
| dma_pkt_off | output | LW | Source offset within packet |
| dma_ack | input | 1 | DMA write completed |
| done_valid | output | 1 | Done word strobe |
| done_complete | output | 1 | Copy complete flag |
| done_more | output | 1 | Packet continues |
| done_len | output | LW | Copied or remaining bytes |
| done_class | output | CW | Packet classification bits |
| irq_dma | output | 1 | Copy-finished event |
| irq_empty | output | 1 | FIFO emptied event |

## Verification
The bench builds the block with LOW_MARK=4 and narrow 16-bit address and 12-bit length fields. This keeps `fifo_level` below the low mark with one or two packets, so short-copy cutting can be reached and turned off with the no-delay flag within a few descriptors. The short-copy size and threshold are driven as 32 and 64. Packets of 200 and 300 bytes then split into several parts, so the continuation, more-flag and offset paths are exercised. Holding `ext_dma_busy` and `tx_wait` keeps a descriptor parked in begin-copy, which fills the pending slot and exposes back-pressure on `desc_ready`.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;
  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_FBLK  = 3'd1,
    S_BEGIN = 3'd2,
    S_COPY  = 3'd3,
    S_DONE  = 3'd4
  } rxdma_state_e;
endpackage

// File: rtl/rxdma_len_calc.sv
module rxdma_len_calc #(
  parameter int LW       = 14,
  parameter int FLW      = 8,
  parameter int LOW_MARK = 4
) (
  input  logic [LW-1:0]  desc_len,
  input  logic [LW-1:0]  remaining,
  input  logic           short_en,
  input  logic           nodelay,
  input  logic [FLW-1:0] fifo_level,
  input  logic [LW-1:0]  short_size,
  input  logic [LW-1:0]  short_thresh,
  output logic [LW-1:0]  xfer_len,
  output logic           cfg_err
);
  localparam logic [FLW-1:0] LOW_LVL = FLW'(LOW_MARK);

  logic [LW-1:0] base_len;
  logic          short_ok;

  always_comb begin
    base_len = (desc_len < remaining) ? desc_len : remaining;
    short_ok = short_en && !nodelay && (fifo_level < LOW_LVL);
    xfer_len = (short_ok && (base_len > short_thresh)) ? short_size : base_len;
    cfg_err  = (short_size >= short_thresh);
  end
endmodule

// File: rtl/rxdma_pkt_track.sv
module rxdma_pkt_track #(
  parameter int LW = 14,
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_fresh,
  input  logic [LW-1:0] fresh_len,
  input  logic [CW-1:0] fresh_class,
  input  logic          commit,
  input  logic [LW-1:0] xfer_len,
  output logic [LW-1:0] remaining,
  output logic [LW-1:0] offset,
  output logic [CW-1:0] cls,
  output logic          cont_active,
  output logic          last
);
  assign last = (xfer_len == remaining);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remaining   <= '0;
      offset      <= '0;
      cls         <= '0;
      cont_active <= 1'b0;
    end else if (load_fresh) begin
      remaining   <= fresh_len;
      offset      <= '0;
      cls         <= fresh_class;
      cont_active <= 1'b0;
    end else if (commit) begin
      if (last) begin
        cont_active <= 1'b0;
      end else begin
        remaining   <= remaining - xfer_len;
        offset      <= offset + xfer_len;
        cont_active <= 1'b1;
      end
    end
  end

  // R3
  copy_in_bounds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (xfer_len <= remaining));

  // R7
  offset_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !last && !load_fresh) |=> (offset == $past(offset) + $past(xfer_len)));
endmodule

// File: rtl/rxdma_seq.sv
module rxdma_seq #(
  parameter int AW       = 32,
  parameter int LW       = 14,
  parameter int CW       = 6,
  parameter int FLW      = 8,
  parameter int LOW_MARK = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           desc_valid,
  output logic           desc_ready,
  input  logic [AW-1:0]  desc_addr,
  input  logic [LW-1:0]  desc_len,
  input  logic           desc_nodelay,
  input  logic           pkt_valid,
  input  logic [LW-1:0]  pkt_len,
  input  logic [CW-1:0]  pkt_class,
  input  logic [FLW-1:0] fifo_level,
  output logic           pkt_pop,
  input  logic           short_en,
  input  logic [LW-1:0]  short_size,
  input  logic [LW-1:0]  short_thresh,
  output logic           cfg_err,
  input  logic           ext_dma_busy,
  input  logic           tx_wait,
  output logic           dma_req_valid,
  input  logic           dma_req_ready,
  output logic [AW-1:0]  dma_addr,
  output logic [LW-1:0]  dma_len,
  output logic [LW-1:0]  dma_pkt_off,
  input  logic           dma_ack,
  output logic           done_valid,
  output logic           done_complete,
  output logic           done_more,
  output logic [LW-1:0]  done_len,
  output logic [CW-1:0]  done_class,
  output logic           irq_dma,
  output logic           irq_empty
);
  import rxdma_pkg::*;

  localparam logic [AW-1:0]  SKIP_ADDR = AW'(1);
  localparam logic [FLW-1:0] ONE_LVL   = FLW'(1);

  rxdma_state_e state, state_nx;

  logic          nxt_full, nxt_nodelay;
  logic [AW-1:0] nxt_addr;
  logic [LW-1:0] nxt_len;
  logic          cur_nodelay;
  logic [AW-1:0] cur_addr;
  logic [LW-1:0] cur_len;
  logic [LW-1:0] xfer_q, calc_len;

  logic          accept, take, load_fresh, commit, skip_dma;
  logic [LW-1:0] remaining, offset;
  logic [CW-1:0] cls;
  logic          cont_active, last;

  assign desc_ready = !nxt_full;
  assign accept     = desc_valid && desc_ready;
  assign take       = (state == S_FBLK) && nxt_full && (cont_active || pkt_valid);
  assign load_fresh = take && !cont_active;
  assign commit     = (state == S_DONE);
  assign skip_dma   = (cur_addr == SKIP_ADDR);
  assign pkt_pop    = commit && last;

  rxdma_len_calc #(.LW(LW), .FLW(FLW), .LOW_MARK(LOW_MARK)) u_len (
    .desc_len     (cur_len),
    .remaining    (remaining),
    .short_en     (short_en),
    .nodelay      (cur_nodelay),
    .fifo_level   (fifo_level),
    .short_size   (short_size),
    .short_thresh (short_thresh),
    .xfer_len     (calc_len),
    .cfg_err      (cfg_err)
  );

  rxdma_pkt_track #(.LW(LW), .CW(CW)) u_trk (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_fresh  (load_fresh),
    .fresh_len   (pkt_len),
    .fresh_class (pkt_class),
    .commit      (commit),
    .xfer_len    (xfer_q),
    .remaining   (remaining),
    .offset      (offset),
    .cls         (cls),
    .cont_active (cont_active),
    .last        (last)
  );

  assign dma_req_valid = (state == S_BEGIN) && !skip_dma && !ext_dma_busy && !tx_wait;
  assign dma_addr      = cur_addr;
  assign dma_len       = calc_len;
  assign dma_pkt_off   = offset;

  always_comb begin
    state_nx = state;
    case (state)
      S_IDLE:  if (nxt_full) state_nx = S_FBLK;
      S_FBLK:  if (take) state_nx = S_BEGIN;
      S_BEGIN: begin
        if (skip_dma) state_nx = S_DONE;
        else if (dma_req_valid && dma_req_ready) state_nx = S_COPY;
      end
      S_COPY:  if (dma_ack) state_nx = S_DONE;
      S_DONE:  state_nx = (nxt_full || accept) ? S_FBLK : S_IDLE;
      default: state_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      nxt_full    <= 1'b0;
      nxt_addr    <= '0;
      nxt_len     <= '0;
      nxt_nodelay <= 1'b0;
      cur_addr    <= '0;
      cur_len     <= '0;
      cur_nodelay <= 1'b0;
      xfer_q      <= '0;
    end else begin
      state <= state_nx;
      if (accept) begin
        nxt_full    <= 1'b1;
        nxt_addr    <= desc_addr;
        nxt_len     <= desc_len;
        nxt_nodelay <= desc_nodelay;
      end else if (take) begin
        nxt_full <= 1'b0;
      end
      if (take) begin
        cur_addr    <= nxt_addr;
        cur_len     <= nxt_len;
        cur_nodelay <= nxt_nodelay;
      end
      if (state == S_BEGIN) xfer_q <= calc_len;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_valid    <= 1'b0;
      done_complete <= 1'b0;
      done_more     <= 1'b0;
      done_len      <= '0;
      done_class    <= '0;
      irq_dma       <= 1'b0;
      irq_empty     <= 1'b0;
    end else begin
      done_valid <= commit;
      irq_dma    <= commit;
      irq_empty  <= pkt_pop && (fifo_level == ONE_LVL);
      if (commit) begin
        done_complete <= 1'b1;
        done_more     <= !last;
        done_len      <= last ? xfer_q : (remaining - xfer_q);
        done_class    <= cls;
      end
    end
  end

  // R9
  req_yield_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_dma_busy || tx_wait) |-> !dma_req_valid);

  // R6
  done_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> (done_complete && irq_dma));

  // R7
  more_keeps_pkt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && done_more) |-> cont_active);

  // R5
  skip_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_BEGIN && skip_dma) |-> !dma_req_valid);

  // R1
  slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nxt_full && !take) |=> !desc_ready);

  // R8
  empty_with_dma_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_empty |-> irq_dma);
endmodule

// File: tb/rxdma_seq_tb.sv
module rxdma_seq_tb;
  localparam int AW = 16, LW = 12, CW = 4, FLW = 4, LOW_MARK = 4;

  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic desc_valid = 0, desc_nodelay = 0, desc_ready;
  logic [AW-1:0] desc_addr = '0;
  logic [LW-1:0] desc_len = '0;
  logic pkt_valid = 0, pkt_pop;
  logic [LW-1:0] pkt_len = '0;
  logic [CW-1:0] pkt_class = '0;
  logic [FLW-1:0] fifo_level = '0;
  logic short_en = 0, cfg_err;
  logic [LW-1:0] short_size = 12'd32, short_thresh = 12'd64;
  logic ext_dma_busy = 0, tx_wait = 0, dma_req_valid, dma_req_ready = 1, dma_ack = 0;
  logic [AW-1:0] dma_addr;
  logic [LW-1:0] dma_len, dma_pkt_off, done_len;
  logic done_valid, done_complete, done_more, irq_dma, irq_empty;
  logic [CW-1:0] done_class;

  rxdma_seq #(.AW(AW), .LW(LW), .CW(CW), .FLW(FLW), .LOW_MARK(LOW_MARK)) u_dut (.*);

  int checks = 0, fails = 0, cyc = 0, req_seen = 0, ack_cnt = 0;
  int pq_len[$], pq_cls[$];
  int ed_more[$], ed_len[$], ed_cls[$], ed_empty[$];
  int er_addr[$], er_len[$], er_off[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void refresh();
    pkt_valid  = (pq_len.size() > 0);
    pkt_len    = pkt_valid ? LW'(pq_len[0]) : '0;
    pkt_class  = pkt_valid ? CW'(pq_cls[0]) : '0;
    fifo_level = FLW'(pq_len.size());
  endfunction

  task automatic push_pkt(input int len, input int cls);
    pq_len.push_back(len); pq_cls.push_back(cls); refresh();
  endtask

  task automatic exp_done(input int more, input int len, input int cls, input int emp);
    ed_more.push_back(more); ed_len.push_back(len); ed_cls.push_back(cls); ed_empty.push_back(emp);
  endtask

  task automatic exp_req(input int a, input int l, input int o);
    er_addr.push_back(a); er_len.push_back(l); er_off.push_back(o);
  endtask

  task automatic send_desc(input int a, input int l, input bit nd);
    desc_addr = AW'(a); desc_len = LW'(l); desc_nodelay = nd; desc_valid = 1;
    @(posedge clk);
    while (!desc_ready) @(posedge clk);
    @(negedge clk);
    desc_valid = 0;
  endtask

  task automatic drain();
    int t = 0;
    while ((ed_len.size() > 0 || er_len.size() > 0) && t < 500) begin @(negedge clk); t++; end
    chk(t < 500, "R1 drain", ed_len.size(), 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // packet FIFO model and DMA acknowledge model
  always @(posedge clk) begin
    if (pkt_pop && pq_len.size() > 0) begin void'(pq_len.pop_front()); void'(pq_cls.pop_front()); end
  end

  always @(negedge clk) begin
    cyc++;
    refresh();
    if (ack_cnt > 0) begin ack_cnt--; dma_ack = (ack_cnt == 0); end
    else dma_ack = 0;
    // monitor: requests
    if (dma_req_valid && dma_req_ready) begin
      req_seen++;
      ack_cnt = 3;
      if (er_len.size() == 0) chk(0, "R5 unexpected request", int'(dma_len), -1);
      else begin
        chk(int'(dma_addr) == er_addr[0], "R3 req addr", int'(dma_addr), er_addr[0]);
        chk(int'(dma_len) == er_len[0], "R3 req len", int'(dma_len), er_len[0]);
        chk(int'(dma_pkt_off) == er_off[0], "R2 req offset", int'(dma_pkt_off), er_off[0]);
        void'(er_addr.pop_front()); void'(er_len.pop_front()); void'(er_off.pop_front());
      end
    end
    // monitor: done words
    if (done_valid) begin
      if (ed_len.size() == 0) chk(0, "R6 unexpected done", int'(done_len), -1);
      else begin
        chk(done_complete == 1, "R6 complete", done_complete, 1);
        chk(int'(done_more) == ed_more[0], "R7 more", done_more, ed_more[0]);
        chk(int'(done_len) == ed_len[0], "R7 done len", int'(done_len), ed_len[0]);
        chk(int'(done_class) == ed_cls[0], "R6 class", int'(done_class), ed_cls[0]);
        chk(irq_dma == 1, "R8 irq_dma", irq_dma, 1);
        chk(int'(irq_empty) == ed_empty[0], "R8 irq_empty", irq_empty, ed_empty[0]);
        void'(ed_more.pop_front()); void'(ed_len.pop_front());
        void'(ed_cls.pop_front()); void'(ed_empty.pop_front());
      end
    end
    if (cyc > 100000) begin
      chk(0, "watchdog", cyc, 100000);
      finish_run();
    end
  end

  initial begin
    int r0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(dma_req_valid == 0, "R11 req", dma_req_valid, 0);
    chk(done_valid == 0 && irq_dma == 0 && irq_empty == 0, "R11 done/irq", done_valid, 0);
    chk(desc_ready == 1, "R11 desc_ready", desc_ready, 1);
    rst_n = 1;
    @(negedge clk);

    // R10 configuration check
    chk(cfg_err == 0, "R10 32<64", cfg_err, 0);
    short_size = 64; #1;
    chk(cfg_err == 1, "R10 64>=64", cfg_err, 1);
    short_size = 32; #1;

    // R3 R6: whole packet fits, last packet -> empty event
    push_pkt(100, 5);
    exp_req('h1000, 100, 0); exp_done(0, 100, 5, 1);
    send_desc('h1000, 200, 0);
    drain();

    // R2 R7: split packet, continuation beats the fresh packet behind it
    push_pkt(300, 3); push_pkt(50, 1);
    exp_req('h2000, 128, 0); exp_done(1, 172, 3, 0);
    send_desc('h2000, 128, 0);
    drain();
    exp_req('h2400, 172, 128); exp_done(0, 172, 3, 0);
    send_desc('h2400, 500, 0);
    drain();
    exp_req('h2800, 50, 0); exp_done(0, 50, 1, 1);
    send_desc('h2800, 64, 0);
    drain();

    // R5: address 1 skips DMA
    r0 = req_seen;
    push_pkt(64, 2);
    exp_done(0, 64, 2, 1);
    send_desc(1, 64, 0);
    drain();
    chk(req_seen == r0, "R5 no request", req_seen - r0, 0);

    // R4: short copy cut, then no-delay disables it, then length under threshold
    short_en = 1;
    push_pkt(200, 4);
    exp_req('h3000, 32, 0); exp_done(1, 168, 4, 0);
    send_desc('h3000, 200, 0);
    drain();
    exp_req('h3100, 168, 32); exp_done(0, 168, 4, 1);
    send_desc('h3100, 200, 1);
    drain();
    push_pkt(60, 6);
    exp_req('h3200, 60, 0); exp_done(0, 60, 6, 1);
    send_desc('h3200, 100, 0);
    drain();
    short_en = 0;

    // R9 R1: yield while busy / tx waits; pending slot back-pressure
    ext_dma_busy = 1;
    r0 = req_seen;
    push_pkt(40, 7); push_pkt(30, 8);
    exp_req('h4000, 40, 0); exp_done(0, 40, 7, 0);
    exp_req('h4100, 30, 0); exp_done(0, 30, 8, 1);
    send_desc('h4000, 40, 0);
    send_desc('h4100, 40, 0);
    repeat (4) @(negedge clk);
    chk(desc_ready == 0, "R1 slot full", desc_ready, 0);
    chk(req_seen == r0, "R9 ext busy", req_seen - r0, 0);
    ext_dma_busy = 0; tx_wait = 1;
    repeat (10) @(negedge clk);
    chk(req_seen == r0, "R9 tx wait", req_seen - r0, 0);
    tx_wait = 0;
    drain();
    chk(req_seen == r0 + 2, "R1 both served", req_seen - r0, 2);
    chk(desc_ready == 1, "R1 slot free", desc_ready, 1);

    finish_run();
  end
endmodule